// File: doc/BRIEF.md
# FM Operator Envelope Generator

This block shapes the loudness of one operator in a four-operator FM voice. It keeps a 10-bit attenuation value, where 0 is full volume and 1023 is silence, and moves it through four phases in a fixed order: attack, first decay, second decay and release. A key-on pulse restarts the envelope from silence in the attack phase. A key-off pulse moves it to release. Between key events the value changes only on cycles where the envelope tick enable is high. That enable is divided down from the master clock elsewhere in the chip.

Each phase has its own raw rate. The block turns the raw rate into an effective rate using the note's keycode and a two-bit scaling field. The effective rate is the number of attenuation units the value moves per tick. Attack lowers the attenuation until it reaches the level set by the total-level input. First decay raises it to a sustain point. Second decay and release raise it until it reaches silence. The current phase is reported on its own output, next to the attenuation.

Top module: `eg_top`

## Requirements
- R1: After a synchronous active-high reset, the phase output is 3 (release) and the attenuation is 1023.
- R2: A key-on pulse makes the next cycle show phase 0 (attack) and attenuation 1023, whether or not a tick is present. The phase codes are 0 attack, 1 first decay, 2 second decay and 3 release.
- R3: A key-off pulse without key-on makes the next cycle show phase 3. The attenuation is left unchanged in that cycle, even if a tick is present.
- R4: When key-on and key-off are high in the same cycle, key-on wins.
- R5: The effective rate is 2·raw + (keycode >> (3 − scale)), where the keycode is 5 bits and scale is 2 bits. Attack, first-decay and second-decay raw rates are 5 bits and the release raw rate is 4 bits. On each tick the attenuation moves by the effective rate of the current phase: down in attack, up in the other phases.
- R6: The effective rate never exceeds 64.
- R7: A raw rate of 0 leaves the attenuation and the phase unchanged on a tick, whatever the keycode.
- R8: On a cycle with no tick and no key event, the attenuation and the phase hold.
- R9: Attack ends on the tick where the attenuation minus the step would reach or fall below the target, 8·total level. That tick sets the attenuation to the target and the phase to 1.
- R10: First decay ends on the tick where the attenuation plus the step would reach or exceed the sustain point, min(8·total level + 32·sustain level, 1023). That tick sets the attenuation to the sustain point and the phase to 2.
- R11: In second decay and release the attenuation rises by the step, stops at 1023, and the phase does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tickEn | input | 1 | Envelope tick enable |
| keyOn | input | 1 | Key-on pulse |
| keyOff | input | 1 | Key-off pulse |
| rateScale | input | 2 | Keycode scaling select |
| keycode | input | 5 | Note keycode |
| attackRate | input | 5 | Attack raw rate |
| decay1Rate | input | 5 | First-decay raw rate |
| decay2Rate | input | 5 | Second-decay raw rate |
| releaseRate | input | 4 | Release raw rate |
| sustainLevel | input | 4 | Sustain level, 32 units per step |
| totalLevel | input | 7 | Total level, 8 units per step |
| atten | output | 10 | Current attenuation |
| phase | output | 2 | Current phase code |

## Verification
Three things can meet in one cycle: a key event, an envelope tick, and the end of a phase. The bench makes them collide on purpose. It asserts key-on together with key-off, asserts key-off together with a tick while in attack, and asserts key-on together with a tick on the exact tick where a phase would have ended. Each case is judged against an arithmetic model of the requirements that is stepped once per clock. Key-on must win over everything. Key-off must change only the phase, not the attenuation.

// File: rtl/eg_pkg.sv
package eg_pkg;
  typedef enum logic [1:0] {
    PH_ATTACK  = 2'd0,
    PH_DECAY1  = 2'd1,
    PH_DECAY2  = 2'd2,
    PH_RELEASE = 2'd3
  } egPhase_e;

  typedef struct packed {
    logic loadSilent;
    logic stepDown;
    logic stepUp;
    logic snapTarget;
    logic snapSustain;
  } egStrobe_t;
endpackage

// File: rtl/eg_rate_calc.sv
module eg_rate_calc #(
  parameter int RATE_W   = 5,
  parameter int KC_W     = 5,
  parameter int RATE_CAP = 64,
  parameter int EFF_W    = 7
) (
  input  logic [RATE_W-1:0] rawRate,
  input  logic [KC_W-1:0]   keycode,
  input  logic [1:0]        rateScale,
  output logic [EFF_W-1:0]  effRate
);
  localparam int SUM_W = ((RATE_W + 1 > KC_W) ? RATE_W + 1 : KC_W) + 1;
  localparam logic [SUM_W-1:0] CAP_S = SUM_W'(RATE_CAP);

  logic [KC_W-1:0]  kcPart;
  logic [SUM_W-1:0] rateSum;

  always_comb begin
    kcPart  = keycode >> (2'd3 - rateScale);
    rateSum = SUM_W'({rawRate, 1'b0}) + SUM_W'(kcPart);
    if (rawRate == '0)
      effRate = '0;
    else if (rateSum > CAP_S)
      effRate = EFF_W'(CAP_S);
    else
      effRate = EFF_W'(rateSum);
  end
endmodule

// File: rtl/eg_ctrl.sv
module eg_ctrl
  import eg_pkg::*;
#(
  parameter int EFF_W = 7
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 tickEn,
  input  logic                 keyOn,
  input  logic                 keyOff,
  input  logic [3:0][EFF_W-1:0] effSet,
  input  logic                 hitTarget,
  input  logic                 hitSustain,
  output egPhase_e             phase,
  output egStrobe_t            strobe,
  output logic [EFF_W-1:0]     stepSel
);
  egPhase_e phaseNext;

  assign stepSel = effSet[phase];

  always_comb begin
    phaseNext = phase;
    strobe    = '0;
    if (keyOn) begin
      phaseNext         = PH_ATTACK;
      strobe.loadSilent = 1'b1;
    end else if (keyOff) begin
      phaseNext = PH_RELEASE;
    end else if (tickEn && stepSel != '0) begin
      unique case (phase)
        PH_ATTACK: begin
          if (hitTarget) begin
            strobe.snapTarget = 1'b1;
            phaseNext         = PH_DECAY1;
          end else begin
            strobe.stepDown = 1'b1;
          end
        end
        PH_DECAY1: begin
          if (hitSustain) begin
            strobe.snapSustain = 1'b1;
            phaseNext          = PH_DECAY2;
          end else begin
            strobe.stepUp = 1'b1;
          end
        end
        default: strobe.stepUp = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) phase <= PH_RELEASE;
    else     phase <= phaseNext;
  end
endmodule

// File: rtl/eg_datapath.sv
module eg_datapath
  import eg_pkg::*;
#(
  parameter int ATTEN_W = 10,
  parameter int TL_W    = 7,
  parameter int SL_W    = 4,
  parameter int EFF_W   = 7
) (
  input  logic               clk,
  input  logic               rst,
  input  egStrobe_t          strobe,
  input  logic [EFF_W-1:0]   step,
  input  logic [TL_W-1:0]    totalLevel,
  input  logic [SL_W-1:0]    sustainLevel,
  output logic [ATTEN_W-1:0] atten,
  output logic               hitTarget,
  output logic               hitSustain
);
  localparam int TL_SHIFT = ATTEN_W - TL_W;
  localparam int SL_SHIFT = ATTEN_W - SL_W - 1;
  localparam logic [ATTEN_W-1:0] ATTEN_MAX = {ATTEN_W{1'b1}};

  logic [ATTEN_W-1:0] target, sustainPt, downVal, upVal;
  logic [ATTEN_W:0]   susSum, upSum, targetPlus, stepWide;

  always_comb begin
    stepWide   = (ATTEN_W + 1)'(step);
    target     = ATTEN_W'(totalLevel) << TL_SHIFT;
    susSum     = {1'b0, target} + ((ATTEN_W + 1)'(sustainLevel) << SL_SHIFT);
    sustainPt  = (susSum > {1'b0, ATTEN_MAX}) ? ATTEN_MAX : susSum[ATTEN_W-1:0];
    targetPlus = {1'b0, target} + stepWide;
    upSum      = {1'b0, atten} + stepWide;
    hitTarget  = {1'b0, atten} <= targetPlus;
    hitSustain = upSum >= {1'b0, sustainPt};
    downVal    = ({1'b0, atten} > stepWide) ? ATTEN_W'({1'b0, atten} - stepWide) : '0;
    upVal      = upSum[ATTEN_W] ? ATTEN_MAX : upSum[ATTEN_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)                     atten <= ATTEN_MAX;
    else if (strobe.loadSilent)  atten <= ATTEN_MAX;
    else if (strobe.snapTarget)  atten <= target;
    else if (strobe.snapSustain) atten <= sustainPt;
    else if (strobe.stepDown)    atten <= downVal;
    else if (strobe.stepUp)      atten <= upVal;
  end
endmodule

// File: rtl/eg_top.sv
module eg_top
  import eg_pkg::*;
#(
  parameter int ATTEN_W  = 10,
  parameter int TL_W     = 7,
  parameter int SL_W     = 4,
  parameter int RATE_W   = 5,
  parameter int REL_W    = 4,
  parameter int KC_W     = 5,
  parameter int RATE_CAP = 64
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tickEn,
  input  logic               keyOn,
  input  logic               keyOff,
  input  logic [1:0]         rateScale,
  input  logic [KC_W-1:0]    keycode,
  input  logic [RATE_W-1:0]  attackRate,
  input  logic [RATE_W-1:0]  decay1Rate,
  input  logic [RATE_W-1:0]  decay2Rate,
  input  logic [REL_W-1:0]   releaseRate,
  input  logic [SL_W-1:0]    sustainLevel,
  input  logic [TL_W-1:0]    totalLevel,
  output logic [ATTEN_W-1:0] atten,
  output logic [1:0]         phase
);
  localparam int EFF_W = $clog2(RATE_CAP + 1);
  localparam int NUM_PH = 4;

  logic [NUM_PH-1:0][RATE_W-1:0] rawSet;
  logic [NUM_PH-1:0][EFF_W-1:0]  effSet;
  logic [EFF_W-1:0]              stepSel;
  logic                          hitTarget, hitSustain;
  egStrobe_t                     strobe;
  egPhase_e                      phaseState;

  assign rawSet[PH_ATTACK]  = attackRate;
  assign rawSet[PH_DECAY1]  = decay1Rate;
  assign rawSet[PH_DECAY2]  = decay2Rate;
  assign rawSet[PH_RELEASE] = RATE_W'(releaseRate);

  for (genvar g = 0; g < NUM_PH; g++) begin : g_rate
    eg_rate_calc #(
      .RATE_W(RATE_W), .KC_W(KC_W), .RATE_CAP(RATE_CAP), .EFF_W(EFF_W)
    ) u_rate (
      .rawRate(rawSet[g]), .keycode(keycode),
      .rateScale(rateScale), .effRate(effSet[g])
    );
  end

  eg_ctrl #(.EFF_W(EFF_W)) u_ctrl (
    .clk(clk), .rst(rst), .tickEn(tickEn), .keyOn(keyOn), .keyOff(keyOff),
    .effSet(effSet), .hitTarget(hitTarget), .hitSustain(hitSustain),
    .phase(phaseState), .strobe(strobe), .stepSel(stepSel)
  );

  eg_datapath #(
    .ATTEN_W(ATTEN_W), .TL_W(TL_W), .SL_W(SL_W), .EFF_W(EFF_W)
  ) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .step(stepSel),
    .totalLevel(totalLevel), .sustainLevel(sustainLevel),
    .atten(atten), .hitTarget(hitTarget), .hitSustain(hitSustain)
  );

  assign phase = phaseState;
endmodule

// File: rtl/eg_top_check.sv
module eg_top_check #(
  parameter int ATTEN_W = 10
) (
  input logic               clk,
  input logic               rst,
  input logic               tickEn,
  input logic               keyOn,
  input logic               keyOff,
  input logic [ATTEN_W-1:0] atten,
  input logic [1:0]         phase
);
  localparam logic [ATTEN_W-1:0] ATTEN_MAX = {ATTEN_W{1'b1}};

  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (phase == 2'd3 && atten == ATTEN_MAX));

  p_keyon_attack_r2: assert property (@(posedge clk) disable iff (rst)
    keyOn |=> (phase == 2'd0 && atten == ATTEN_MAX));

  p_keyoff_release_r3: assert property (@(posedge clk) disable iff (rst)
    (!keyOn && keyOff) |=> (phase == 2'd3 && $stable(atten)));

  p_idle_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (!keyOn && !keyOff && !tickEn) |=> ($stable(atten) && $stable(phase)));

  p_attack_falls_r5: assert property (@(posedge clk) disable iff (rst)
    (phase == 2'd0 && !keyOn) |=> (atten <= $past(atten)));

  p_late_rise_r11: assert property (@(posedge clk) disable iff (rst)
    (phase[1] && !keyOn) |=> (atten >= $past(atten) && phase[1]));
endmodule

bind eg_top eg_top_check #(.ATTEN_W(ATTEN_W)) u_check (
  .clk(clk), .rst(rst), .tickEn(tickEn), .keyOn(keyOn), .keyOff(keyOff),
  .atten(atten), .phase(phase)
);

// File: tb/eg_top_test.sv
`timescale 1ns/1ps
module eg_top_test;
  logic       clk = 1'b0;
  logic       rst, tickEn, keyOn, keyOff;
  logic [1:0] rateScale;
  logic [4:0] keycode, attackRate, decay1Rate, decay2Rate;
  logic [3:0] releaseRate, sustainLevel;
  logic [6:0] totalLevel;
  logic [9:0] atten;
  logic [1:0] phase;

  int checks = 0;
  int fails  = 0;
  int mAtten, mPhase;
  bit done = 0;

  always #2.5 clk = ~clk;

  eg_top uut (
    .clk(clk), .rst(rst), .tickEn(tickEn), .keyOn(keyOn), .keyOff(keyOff),
    .rateScale(rateScale), .keycode(keycode), .attackRate(attackRate),
    .decay1Rate(decay1Rate), .decay2Rate(decay2Rate), .releaseRate(releaseRate),
    .sustainLevel(sustainLevel), .totalLevel(totalLevel),
    .atten(atten), .phase(phase)
  );

  function automatic int effOf(int raw);
    int v;
    if (raw == 0) return 0;
    v = 2 * raw + (int'(keycode) >> (3 - int'(rateScale)));
    return (v > 64) ? 64 : v;
  endfunction

  function automatic int rawOf(int ph);
    case (ph)
      0: return int'(attackRate);
      1: return int'(decay1Rate);
      2: return int'(decay2Rate);
      default: return int'(releaseRate);
    endcase
  endfunction

  task automatic modelStep(input bit kon, input bit koff, input bit tk);
    int r, tgt, sus;
    tgt = 8 * int'(totalLevel);
    sus = tgt + 32 * int'(sustainLevel);
    if (sus > 1023) sus = 1023;
    if (kon) begin
      mAtten = 1023; mPhase = 0;
    end else if (koff) begin
      mPhase = 3;
    end else if (tk) begin
      r = effOf(rawOf(mPhase));
      if (r != 0) begin
        if (mPhase == 0) begin
          if (mAtten - r <= tgt) begin mAtten = tgt; mPhase = 1; end
          else mAtten = mAtten - r;
        end else if (mPhase == 1) begin
          if (mAtten + r >= sus) begin mAtten = sus; mPhase = 2; end
          else mAtten = mAtten + r;
        end else begin
          mAtten = (mAtten + r > 1023) ? 1023 : mAtten + r;
        end
      end
    end
  endtask

  task automatic compare(input string tag);
    checks++;
    if (int'(atten) != mAtten || int'(phase) != mPhase) begin
      fails++;
      $display("FAIL %s: atten=%0d phase=%0d expected atten=%0d phase=%0d",
               tag, atten, phase, mAtten, mPhase);
    end
  endtask

  task automatic doCycle(input bit kon, input bit koff, input bit tk, input string tag);
    keyOn = kon; keyOff = koff; tickEn = tk;
    @(posedge clk);
    modelStep(kon, koff, tk);
    @(negedge clk);
    keyOn = 0; keyOff = 0; tickEn = 0;
    compare(tag);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run hung, actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst = 1; tickEn = 0; keyOn = 0; keyOff = 0;
    rateScale = 0; keycode = 0; attackRate = 0; decay1Rate = 0;
    decay2Rate = 0; releaseRate = 0; sustainLevel = 0; totalLevel = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    mAtten = 1023; mPhase = 3;
    compare("R1 reset state");

    // R5 R6 R7: sweep scale, keycode and attack raw rate, one attack tick each
    for (int s = 0; s < 4; s++)
      for (int k = 0; k < 32; k++)
        for (int a = 0; a < 32; a++) begin
          rateScale = 2'(s); keycode = 5'(k); attackRate = 5'(a); totalLevel = 0;
          doCycle(1, 0, 0, "R2 key-on restart");
          if (a == 0) doCycle(0, 0, 1, "R7 zero rate holds");
          else if (effOf(a) == 64) doCycle(0, 0, 1, "R6 rate cap");
          else doCycle(0, 0, 1, "R5 effective rate step");
        end

    // Full envelope: R9, R10, R11
    rateScale = 2'd1; keycode = 5'd8; attackRate = 5'd10; decay1Rate = 5'd3;
    decay2Rate = 5'd2; releaseRate = 4'd5; totalLevel = 7'd20; sustainLevel = 4'd5;
    doCycle(1, 0, 0, "R2 key-on");
    for (int i = 0; i < 60; i++) doCycle(0, 0, 1, "R9 attack to target");
    for (int i = 0; i < 60; i++) doCycle(0, 0, 1, "R10 decay to sustain");
    for (int i = 0; i < 150; i++) doCycle(0, 0, 1, "R11 second decay saturates");
    // R8: idle cycles hold
    for (int i = 0; i < 5; i++) doCycle(0, 0, 0, "R8 no tick holds");

    // R3: key-off with tick in attack leaves atten unchanged
    doCycle(1, 0, 0, "R2 key-on");
    for (int i = 0; i < 5; i++) doCycle(0, 0, 1, "R5 attack steps");
    doCycle(0, 1, 1, "R3 key-off with tick");
    for (int i = 0; i < 100; i++) doCycle(0, 0, 1, "R11 release saturates");

    // R4: key-on and key-off together
    doCycle(1, 1, 1, "R4 key-on wins");
    doCycle(0, 0, 1, "R4 attack continues");

    // R4 with a phase end pending: key-on together with the ending tick
    totalLevel = 7'd126; attackRate = 5'd31;
    doCycle(1, 0, 0, "R2 key-on");
    doCycle(1, 0, 1, "R4 key-on over phase end");
    doCycle(0, 0, 1, "R9 target reached");

    // R7: zero release rate holds in release
    releaseRate = 4'd0; keycode = 5'd31; rateScale = 2'd3;
    doCycle(0, 1, 0, "R3 key-off");
    for (int i = 0; i < 4; i++) doCycle(0, 0, 1, "R7 zero release rate");

    // R10: sustain point clipped at 1023
    totalLevel = 7'd127; sustainLevel = 4'd15; attackRate = 5'd31;
    decay1Rate = 5'd1; rateScale = 2'd0; keycode = 5'd0;
    doCycle(1, 0, 0, "R2 key-on");
    for (int i = 0; i < 10; i++) doCycle(0, 0, 1, "R10 sustain clip");

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule